// File: doc/BRIEF.md
# Video and Sliced-Text Output Arbiter

This block gathers two independent word streams, scaled video and sliced text data, into one outgoing 32-bit word port. Each stream lands in its own 16-entry FIFO. An arbiter picks which FIFO's head word drives the shared port, under two configuration bits. One bit sets text-first or video-first priority. The other mutes text output altogether. A marker output is raised while a text word is on the port, so downstream logic can tell the two kinds of payload apart.

The outgoing port is valid/ready. A presented word is a commitment. Once `out_valid` is high, the source and the word stay fixed until `out_ready` is seen high on a clock edge, even if the configuration changes in the meantime. Source changes therefore happen only between words.

The incoming streams are plain write strobes with no back-pressure. A producer that needs to throttle watches the per-FIFO empty, full and programmable "filled" flags. A write that arrives while a FIFO is full is discarded and latches a sticky overflow flag for that FIFO.

Top module: `vsd_out_arb`

## Requirements
- R1: Each FIFO delivers its words on the port in the order they were written, with the data unchanged.
- R2: With `cfg_txt_first`=1 and `cfg_txt_off`=0, a new grant goes to the text FIFO whenever it holds a word. Otherwise it goes to video.
- R3: With `cfg_txt_first`=0, a new grant goes to video whenever the video FIFO holds a word. Text is granted only when video is empty (and `cfg_txt_off`=0).
- R4: With `cfg_txt_off`=1, no new text grant is made. Text words stay stored in their FIFO.
- R5: While `out_valid`=1 and `out_ready`=0, on the next cycle `out_valid` stays 1 and `out_data` and `out_src` are unchanged. A word leaves its FIFO only on a clock edge where `out_valid` and `out_ready` are both 1.
- R6: `out_src` is 0 for a video word and 1 for a text word. `out_txt_mark` is 1 exactly when `out_valid`=1 and `out_src`=1.
- R7: `fifo_empty[i]` is 1 when FIFO i holds 0 words. `fifo_full[i]` is 1 when it holds 16 words. Index 0 is video and index 1 is text.
- R8: `fifo_filled[i]` is 1 when the occupancy of FIFO i is greater than or equal to `cfg_fill_lvl`. A level of 0 keeps the flag at 1.
- R9: A write to a full FIFO is dropped, even if a read happens on the same edge. The stored words are unaffected.
- R10: `fifo_ovf[i]` sets on the edge after a dropped write to FIFO i. It stays set until an edge with `ovf_clr`=1 and no new dropped write; a new dropped write wins over the clear.
- R11: During reset both FIFOs are empty, `out_valid` is 0 and both overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_we | input | 1 | Video word write strobe |
| vid_wdata | input | 32 | Video word |
| txt_we | input | 1 | Sliced-text word write strobe |
| txt_wdata | input | 32 | Sliced-text word |
| cfg_txt_first | input | 1 | 1: text has priority; 0: video has priority |
| cfg_txt_off | input | 1 | 1: text output muted |
| cfg_fill_lvl | input | 5 | Occupancy threshold for the filled flags (0..16) |
| ovf_clr | input | 1 | Clears both overflow flags |
| out_valid | output | 1 | Port word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Port word |
| out_src | output | 1 | Source tag: 0 video, 1 text |
| out_txt_mark | output | 1 | High while a text word is presented |
| fifo_empty | output | 2 | Empty flags (bit 0 video, bit 1 text) |
| fifo_full | output | 2 | Full flags |
| fifo_filled | output | 2 | Threshold flags |
| fifo_ovf | output | 2 | Sticky overflow flags |

## Verification
Writes and pops take effect on a clock edge. The port outputs and the empty/full flags then reflect the new occupancy in the same cycle after that edge, with no extra register stage. The filled flags also follow `cfg_fill_lvl` combinationally. Overflow flags appear one edge after the dropped write. The bench drives inputs on the falling edge and waits a short settle time. It compares every output against a queue-based reference in that same half cycle, then advances the reference as the coming rising edge will: pop, then push, then overflow and lock update.

// File: rtl/vsd_arb_pkg.sv
package vsd_arb_pkg;
  typedef enum logic {
    SRC_VID = 1'b0,
    SRC_TXT = 1'b1
  } src_e;

  localparam int unsigned N_SRC = 2;
endpackage

// File: rtl/vsd_fifo.sv
module vsd_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [CW-1:0] fill_lvl,
  input  logic          ovf_clr,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          filled,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop, drop;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign filled = (cnt_q >= fill_lvl);
  assign push   = wr_en && !full;
  assign drop   = wr_en && full;
  assign pop    = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wp_q <= wp_q + AW'(1);
      if (pop)  rp_q <= rp_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/vsd_arb_core.sv
module vsd_arb_core
  import vsd_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vid_empty,
  input  logic txt_empty,
  input  logic cfg_txt_first,
  input  logic cfg_txt_off,
  input  logic out_ready,
  output logic out_valid,
  output src_e src,
  output logic vid_pop,
  output logic txt_pop
);
  logic lock_q;
  src_e lock_src_q;
  logic txt_ok, vid_ok;
  src_e pick;

  assign txt_ok = !txt_empty && !cfg_txt_off;
  assign vid_ok = !vid_empty;

  always_comb begin
    if (cfg_txt_first) pick = txt_ok ? SRC_TXT : SRC_VID;
    else               pick = (!vid_ok && txt_ok) ? SRC_TXT : SRC_VID;
  end

  assign src       = lock_q ? lock_src_q : pick;
  assign out_valid = lock_q || txt_ok || vid_ok;
  assign vid_pop   = out_valid && out_ready && (src == SRC_VID);
  assign txt_pop   = out_valid && out_ready && (src == SRC_TXT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_src_q <= SRC_VID;
    end else begin
      lock_q     <= out_valid && !out_ready;
      lock_src_q <= src;
    end
  end
endmodule

// File: rtl/vsd_out_arb.sv
module vsd_out_arb
  import vsd_arb_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vid_we,
  input  logic [DW-1:0] vid_wdata,
  input  logic          txt_we,
  input  logic [DW-1:0] txt_wdata,
  input  logic          cfg_txt_first,
  input  logic          cfg_txt_off,
  input  logic [CW-1:0] cfg_fill_lvl,
  input  logic          ovf_clr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_src,
  output logic          out_txt_mark,
  output logic [1:0]    fifo_empty,
  output logic [1:0]    fifo_full,
  output logic [1:0]    fifo_filled,
  output logic [1:0]    fifo_ovf
);
  logic [N_SRC-1:0]         we_v, pop_v;
  logic [N_SRC-1:0][DW-1:0] wd_v, rd_v;
  src_e                     sel;

  assign we_v = {txt_we, vid_we};
  assign wd_v = {txt_wdata, vid_wdata};

  for (genvar g = 0; g < N_SRC; g++) begin : g_fifo
    vsd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (we_v[g]),
      .wr_data (wd_v[g]),
      .rd_en   (pop_v[g]),
      .fill_lvl(cfg_fill_lvl),
      .ovf_clr (ovf_clr),
      .rd_data (rd_v[g]),
      .empty   (fifo_empty[g]),
      .full    (fifo_full[g]),
      .filled  (fifo_filled[g]),
      .ovf     (fifo_ovf[g])
    );
  end

  vsd_arb_core u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .vid_empty    (fifo_empty[0]),
    .txt_empty    (fifo_empty[1]),
    .cfg_txt_first(cfg_txt_first),
    .cfg_txt_off  (cfg_txt_off),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .src          (sel),
    .vid_pop      (pop_v[0]),
    .txt_pop      (pop_v[1])
  );

  assign out_src      = (sel == SRC_TXT);
  assign out_data     = out_src ? rd_v[1] : rd_v[0];
  assign out_txt_mark = out_valid && out_src;
endmodule

// File: rtl/vsd_out_arb_chk.sv
module vsd_out_arb_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_txt_first,
  input logic          cfg_txt_off,
  input logic          ovf_clr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_src,
  input logic          out_txt_mark,
  input logic [1:0]    fifo_empty,
  input logic [1:0]    fifo_full,
  input logic [1:0]    fifo_ovf
);
  // R5
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_src)));

  // R4
  txt_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!(out_valid && !out_ready)) && cfg_txt_off && out_valid) |-> !out_src);

  // R2
  txt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!(out_valid && !out_ready)) && cfg_txt_first && !cfg_txt_off && !fifo_empty[1])
      |-> (out_valid && out_src));

  // R6
  mark_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_txt_mark |-> !fifo_empty[1]);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_empty[0], fifo_full[0]}) && $onehot0({fifo_empty[1], fifo_full[1]}));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf[0] && !ovf_clr) |=> fifo_ovf[0]);
endmodule

bind vsd_out_arb vsd_out_arb_chk #(.DW(DW), .CW(CW)) i_vsd_out_arb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_txt_first(cfg_txt_first),
  .cfg_txt_off  (cfg_txt_off),
  .ovf_clr      (ovf_clr),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_src      (out_src),
  .out_txt_mark (out_txt_mark),
  .fifo_empty   (fifo_empty),
  .fifo_full    (fifo_full),
  .fifo_ovf     (fifo_ovf)
);

// File: tb/test_vsd_out_arb.sv
module test_vsd_out_arb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vid_we = 1'b0, txt_we = 1'b0;
  logic [31:0] vid_wdata = '0, txt_wdata = '0;
  logic        cfg_txt_first = 1'b0, cfg_txt_off = 1'b0, ovf_clr = 1'b0;
  logic [4:0]  cfg_fill_lvl = 5'd4;
  logic        out_ready = 1'b0;
  logic        out_valid, out_src, out_txt_mark;
  logic [31:0] out_data;
  logic [1:0]  fifo_empty, fifo_full, fifo_filled, fifo_ovf;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] vq[$];
  logic [31:0] tq[$];
  bit mlock = 0, msrc = 0;
  bit [1:0] movf = 0;

  always #5 clk = ~clk;

  vsd_out_arb i_vsd_out_arb (
    .clk(clk), .rst_n(rst_n),
    .vid_we(vid_we), .vid_wdata(vid_wdata),
    .txt_we(txt_we), .txt_wdata(txt_wdata),
    .cfg_txt_first(cfg_txt_first), .cfg_txt_off(cfg_txt_off),
    .cfg_fill_lvl(cfg_fill_lvl), .ovf_clr(ovf_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_src(out_src), .out_txt_mark(out_txt_mark),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_filled(fifo_filled), .fifo_ovf(fifo_ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_valid();
    if (mlock) return 1'b1;
    return (tq.size() > 0 && !cfg_txt_off) || (vq.size() > 0);
  endfunction

  function automatic bit exp_src();
    bit tok, vok;
    if (mlock) return msrc;
    tok = tq.size() > 0 && !cfg_txt_off;
    vok = vq.size() > 0;
    if (cfg_txt_first) return tok;
    return !vok && tok;
  endfunction

  function automatic bit [1:0] exp_flags(input int which);
    int nv = vq.size(), nt = tq.size();
    case (which)
      0: return {nt == 0, nv == 0};
      1: return {nt == DEPTH, nv == DEPTH};
      default: return {nt >= int'(cfg_fill_lvl), nv >= int'(cfg_fill_lvl)};
    endcase
  endfunction

  // Inputs are already driven; settle, compare, advance model, wait for next negedge.
  task automatic cycle();
    bit ev, es;
    logic [31:0] ed;
    bit [1:0] drop;
    #1;
    ev = exp_valid();
    es = exp_src();
    ed = ev ? (es ? tq[0] : vq[0]) : 32'h0;
    chk(out_valid == ev, "R2 R3 R4 R5 out_valid", 32'(out_valid), 32'(ev));
    if (ev) begin
      chk(out_src == es, "R2 R3 R4 R5 out_src", 32'(out_src), 32'(es));
      chk(out_data == ed, "R1 out_data", out_data, ed);
    end
    chk(out_txt_mark == (ev && es), "R6 marker", 32'(out_txt_mark), 32'(ev && es));
    chk(fifo_empty == exp_flags(0), "R7 empty", 32'(fifo_empty), 32'(exp_flags(0)));
    chk(fifo_full == exp_flags(1), "R7 full", 32'(fifo_full), 32'(exp_flags(1)));
    chk(fifo_filled == exp_flags(2), "R8 filled", 32'(fifo_filled), 32'(exp_flags(2)));
    chk(fifo_ovf == movf, "R10 ovf", 32'(fifo_ovf), 32'(movf));
    // advance model as the rising edge will: drops judged on pre-edge occupancy (R9)
    drop[0] = vid_we && vq.size() == DEPTH;
    drop[1] = txt_we && tq.size() == DEPTH;
    if (ev && out_ready) begin
      if (es) void'(tq.pop_front()); else void'(vq.pop_front());
    end
    if (vid_we && !drop[0]) vq.push_back(vid_wdata);
    if (txt_we && !drop[1]) tq.push_back(txt_wdata);
    for (int i = 0; i < 2; i++) begin
      if (drop[i]) movf[i] = 1'b1;
      else if (ovf_clr) movf[i] = 1'b0;
    end
    mlock = ev && !out_ready;
    msrc = es;
    @(negedge clk);
  endtask

  task automatic idle();
    vid_we = 0; txt_we = 0; ovf_clr = 0;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    // R11 reset state
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11 reset valid", 32'(out_valid), 0);
    chk(fifo_empty == 2'b11, "R11 reset empty", 32'(fifo_empty), 3);
    chk(fifo_ovf == 2'b00, "R11 reset ovf", 32'(fifo_ovf), 0);
    chk(fifo_full == 2'b00, "R11 reset full", 32'(fifo_full), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed R9/R10: overfill video FIFO with port stalled
    out_ready = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      vid_we = 1; vid_wdata = 32'hA000_0000 + i;
      cycle();
    end
    idle();
    cycle();
    #1;
    chk(fifo_full[0] == 1'b1, "R9 full after overfill", 32'(fifo_full[0]), 1);
    chk(fifo_ovf[0] == 1'b1, "R10 ovf set", 32'(fifo_ovf[0]), 1);
    chk(out_data == 32'hA000_0000, "R9 head intact", out_data, 32'hA000_0000);
    @(negedge clk);
    // write to full while popping: still dropped (R9)
    out_ready = 1; vid_we = 1; vid_wdata = 32'hDEAD_0001;
    cycle();
    idle(); out_ready = 0;
    cycle();
    #1;
    chk(fifo_full[0] == 1'b0, "R9 drop with pop", 32'(fifo_full[0]), 0);
    @(negedge clk);
    ovf_clr = 1;
    cycle();
    idle();
    #1;
    chk(fifo_ovf[0] == 1'b0, "R10 ovf cleared", 32'(fifo_ovf[0]), 0);
    @(negedge clk);

    // Directed R2/R3/R4: text pending with video pending, stall then vary config
    txt_we = 1; txt_wdata = 32'h7E47_0001;
    cycle();
    idle();
    cfg_txt_first = 1; cfg_txt_off = 1;
    cycle();
    #1;
    chk(out_src == 1'b0, "R4 muted text", 32'(out_src), 0);
    @(negedge clk);
    cfg_txt_off = 0; out_ready = 1;
    cycle();
    cfg_txt_first = 0;
    // threshold boundary R8
    for (int lv = 0; lv <= DEPTH; lv += 5) begin
      cfg_fill_lvl = 5'(lv);
      cycle();
    end

    // Constrained random
    for (int i = 0; i < 6000; i++) begin
      int ph = (i / 500) % 4;
      vid_we = ($urandom_range(0, 99) < (ph == 0 ? 70 : 35));
      vid_wdata = $urandom();
      txt_we = ($urandom_range(0, 99) < (ph == 1 ? 60 : 20));
      txt_wdata = $urandom();
      out_ready = ($urandom_range(0, 99) < (ph == 2 ? 90 : 45));
      ovf_clr = ($urandom_range(0, 99) < 3);
      if ($urandom_range(0, 99) < 5) cfg_txt_first = $urandom_range(0, 1);
      if ($urandom_range(0, 99) < 3) cfg_txt_off = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 99) < 4) cfg_fill_lvl = 5'($urandom_range(0, DEPTH));
      cycle();
    end
    idle(); cfg_txt_off = 0; out_ready = 1;
    repeat (40) cycle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule